// File: doc/BRIEF.md
# Word-Parallel 33-bit Shift-Register Random Generator

This block produces pseudo-random 32-bit words from a 33-bit shift register with exclusive-OR feedback. The register has two feedback taps. Counting bit positions from 1 at the least significant end, each single-bit iteration XORs bit 33 with bit 20, shifts the whole 33-bit value one place toward the most significant end, and puts the XOR result into bit 1. These two taps give a maximal-length sequence of 2^33-1 states before it repeats.

An advance strobe runs 32 of these iterations in a single clock, so every strobe brings a whole new 32-bit word to the output. The block is seeded with a 32-bit word plus one extra bit. Together they form the full 33-bit state. The state is presented back in the same split form: the low 32 bits as the random word, and the most significant bit on its own pin.

The all-zero state never changes under the feedback rule, so it is kept out of the register. Reset loads a fixed nonzero value, and a load of an all-zero seed loads a fixed substitute value instead.

Top module: `wordlfsr_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises with no other activity, the state is the constant 33'h0ACE12345: `rnd_top` = 0 and `rnd_word` = 32'hACE12345.
- R2: A cycle with `load_en` high and a nonzero `{seed_hi, seed_lo}` makes the state equal to `{seed_hi, seed_lo}` after that clock edge.
- R3: A cycle with `load_en` high and `{seed_hi, seed_lo}` all zero makes the state 33'h000000001 after that clock edge (`rnd_word` = 1, `rnd_top` = 0).
- R4: When `load_en` and `adv` are both high, the load is performed and the advance is ignored.
- R5: A cycle with `adv` high and `load_en` low replaces the state with the result of 32 iterations. In each iteration, new bit = state[32] XOR state[19] (zero-based indices), and the state becomes {state[31:0], new bit}.
- R6: After an advance, `rnd_top` equals bit 0 of `rnd_word` as it was before that advance.
- R7: A cycle with both `load_en` and `adv` low leaves `rnd_word` and `rnd_top` unchanged.
- R8: Outside reset, the 33-bit state `{rnd_top, rnd_word}` is never all zero.
- R9: Over 1024 consecutive advances from one seed, no 33-bit state appears twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; loads the nonzero reset constant |
| load_en | input | 1 | Load the seed into the state; wins over `adv` |
| seed_lo | input | 32 | Low 32 bits of the seed |
| seed_hi | input | 1 | Bit 33 of the seed |
| adv | input | 1 | Advance the register by 32 iterations |
| rnd_word | output | 32 | Low 32 bits of the state, the random word |
| rnd_top | output | 1 | Most significant state bit |

## Verification
The bench checks every advance against a bit-serial model that iterates 32 times. A design with a wrong tap, an off-by-one bit numbering or a shift in the wrong direction therefore diverges on the first random step. It also drives load and advance together, which catches a design that lets the advance win or merges the two operations. It loads an all-zero seed, which catches a design that would lock up on zero. It runs a long chain of advances from one seed and looks for any repeated state, which catches a design that iterates too few times or picks taps that give a short cycle.

// File: rtl/lfsr33_pkg.sv
package lfsr33_pkg;
    localparam int STATE_W = 33;
    localparam int WORD_W  = STATE_W - 1;
    localparam int TAP_HI  = 33;
    localparam int TAP_LO  = 20;
    localparam int ITERS   = 32;

    localparam logic [STATE_W-1:0] RST_VAL  = 33'h0ACE12345;
    localparam logic [STATE_W-1:0] ZERO_SUB = 33'h000000001;

    typedef struct packed {
        logic [STATE_W-1:0] st;
    } gen_reg_t;
endpackage

// File: rtl/lfsr_unroll.sv
module lfsr_unroll #(
    parameter int W      = 33,
    parameter int TAP_A  = 33,
    parameter int TAP_B  = 20,
    parameter int ITERS  = 32
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] chain [0:ITERS];

    assign chain[0] = cur_i;

    // one feedback stage per iteration, chained combinationally
    for (genvar k = 0; k < ITERS; k++) begin : g_it
        logic fb;
        assign fb           = chain[k][TAP_A-1] ^ chain[k][TAP_B-1];
        assign chain[k+1]   = {chain[k][W-2:0], fb};
    end

    assign nxt_o = chain[ITERS];
endmodule

// File: rtl/lfsr_seed_sel.sv
module lfsr_seed_sel #(
    parameter int             W        = 33,
    parameter logic [W-1:0]   ZERO_SUB = 1
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] safe_o
);
    // an all-zero state would never leave zero: substitute a fixed value
    assign safe_o = (raw_i == '0) ? ZERO_SUB : raw_i;
endmodule

// File: rtl/wordlfsr_gen.sv
module wordlfsr_gen
    import lfsr33_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] seed_lo,
    input  logic              seed_hi,
    input  logic              adv,
    output logic [WORD_W-1:0] rnd_word,
    output logic              rnd_top
);
    gen_reg_t           reg_d, reg_q;
    logic [STATE_W-1:0] seed_safe;
    logic [STATE_W-1:0] stepped;

    lfsr_seed_sel #(
        .W        (STATE_W),
        .ZERO_SUB (ZERO_SUB)
    ) u_seed (
        .raw_i  ({seed_hi, seed_lo}),
        .safe_o (seed_safe)
    );

    lfsr_unroll #(
        .W     (STATE_W),
        .TAP_A (TAP_HI),
        .TAP_B (TAP_LO),
        .ITERS (ITERS)
    ) u_step (
        .cur_i (reg_q.st),
        .nxt_o (stepped)
    );

    always_comb begin
        reg_d = reg_q;
        if (load_en) begin
            reg_d.st = seed_safe;
        end else if (adv) begin
            reg_d.st = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.st <= RST_VAL;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rnd_word = reg_q.st[WORD_W-1:0];
    assign rnd_top  = reg_q.st[STATE_W-1];
endmodule

// File: rtl/wordlfsr_gen_chk.sv
module wordlfsr_gen_chk
    import lfsr33_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [WORD_W-1:0] seed_lo,
    input logic              seed_hi,
    input logic              adv,
    input logic [WORD_W-1:0] rnd_word,
    input logic              rnd_top
);
    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && ({seed_hi, seed_lo} != '0)) |=> ({rnd_top, rnd_word} == $past({seed_hi, seed_lo})));

    // R3
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && ({seed_hi, seed_lo} == '0)) |=> ({rnd_top, rnd_word} == ZERO_SUB));

    // R6
    top_from_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load_en) |=> (rnd_top == $past(rnd_word[0])));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !adv) |=> $stable({rnd_top, rnd_word}));

    // R8
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({rnd_top, rnd_word} != '0));
endmodule

bind wordlfsr_gen wordlfsr_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .seed_lo  (seed_lo),
    .seed_hi  (seed_hi),
    .adv      (adv),
    .rnd_word (rnd_word),
    .rnd_top  (rnd_top)
);

// File: tb/wordlfsr_gen_tb_top.sv
`timescale 1ns/1ps
module wordlfsr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] seed_lo = '0;
    logic        seed_hi = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] rnd_word;
    logic        rnd_top;

    int checks = 0;
    int errors = 0;
    logic [32:0] exp_st;
    logic [32:0] hist [0:1023];

    always #5 clk = ~clk;

    wordlfsr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .seed_lo(seed_lo),
        .seed_hi(seed_hi), .adv(adv), .rnd_word(rnd_word), .rnd_top(rnd_top)
    );

    function automatic logic [32:0] ref_step(input logic [32:0] s);
        logic [32:0] t = s;
        for (int i = 0; i < 32; i++) begin
            t = {t[31:0], t[32] ^ t[19]};
        end
        return t;
    endfunction

    function automatic logic [32:0] ref_next(input logic [32:0] s, input logic ld,
                                             input logic [32:0] sd, input logic av);
        if (ld) return (sd == '0) ? 33'h000000001 : sd;
        if (av) return ref_step(s);
        return s;
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, the result is visible by the next falling edge
    task automatic cyc(input logic ld, input logic [32:0] sd, input logic av);
        load_en = ld; {seed_hi, seed_lo} = sd; adv = av;
        exp_st = ref_next(exp_st, ld, sd, av);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [32:0] prev;
        void'($urandom(32'h5EED_0042));
        @(negedge clk); @(negedge clk);
        check("R1 in reset", {rnd_top, rnd_word}, 33'h0ACE12345);
        rst_n = 1'b1;
        exp_st = 33'h0ACE12345;
        @(negedge clk);
        check("R1 after reset", {rnd_top, rnd_word}, 33'h0ACE12345);

        // R7 idle hold
        cyc(1'b0, '0, 1'b0);
        check("R7 idle", {rnd_top, rnd_word}, exp_st);

        // R5 first step from reset value
        prev = {rnd_top, rnd_word};
        cyc(1'b0, '0, 1'b1);
        check("R5 step", {rnd_top, rnd_word}, exp_st);
        check("R6 top bit", {32'd0, rnd_top}, {32'd0, prev[0]});

        // R2 nonzero load, including top bit set
        cyc(1'b1, 33'h1_8000_0001, 1'b0);
        check("R2 load", {rnd_top, rnd_word}, 33'h1_8000_0001);

        // R3 all-zero load
        cyc(1'b1, 33'h0, 1'b0);
        check("R3 zero seed", {rnd_top, rnd_word}, 33'h000000001);
        cyc(1'b0, '0, 1'b1);
        check("R5 step from substitute", {rnd_top, rnd_word}, exp_st);

        // R4 load and advance together
        cyc(1'b1, 33'h0_DEAD_BEEF, 1'b1);
        check("R4 load priority", {rnd_top, rnd_word}, 33'h0_DEAD_BEEF);
        cyc(1'b1, 33'h0, 1'b1);
        check("R4 zero load priority", {rnd_top, rnd_word}, 33'h000000001);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic        ld = ($urandom % 8) == 0;
            logic        av = ($urandom % 2) == 1;
            logic [32:0] sd = (($urandom % 6) == 0) ? 33'h0 : {1'($urandom), 32'($urandom)};
            prev = {rnd_top, rnd_word};
            cyc(ld, sd, av);
            check(ld ? "R2/R3/R4 random load" : (av ? "R5 random step" : "R7 random idle"),
                  {rnd_top, rnd_word}, exp_st);
            if (!ld && av)
                check("R6 random top bit", {32'd0, rnd_top}, {32'd0, prev[0]});
            if ({rnd_top, rnd_word} == '0)
                check("R8 nonzero", {rnd_top, rnd_word}, 33'h1);
        end

        // R9 long run without repeats
        cyc(1'b1, 33'h1_0000_0000, 1'b0);
        for (int n = 0; n < 1024; n++) begin
            cyc(1'b0, '0, 1'b1);
            hist[n] = {rnd_top, rnd_word};
            check("R5 long run", {rnd_top, rnd_word}, exp_st);
        end
        begin
            int dup = 0;
            for (int a = 0; a < 1024; a++)
                for (int b = a + 1; b < 1024; b++)
                    if (hist[a] == hist[b]) dup++;
            check("R9 no repeat", 33'(dup), 33'd0);
        end
        finish_run();
    end
endmodule